// File: doc/BRIEF.md
# Multi-Format Audio Serial Output Port

This block turns four parallel 24-bit audio samples per frame into serial bit streams. The stream is timed by an externally supplied bit clock and frame sync. A 2-bit format select picks one of three framings at run time. In time-division multiplexed (TDM) framing, all four channels leave on one pin within one frame-sync period. In left-justified and I²S framing, two data pins each carry a pair of channels. The framings share one bit counter and one bit-selection path, so a format change costs no extra datapath.

Samples are written into a staging register with a load strobe. They are copied into a holding register at each frame start, so a write that arrives mid-frame only affects the next frame. The frame-sync level is sampled on every falling bit-clock edge, and every data bit is launched on a falling edge so that a receiver can latch it on the rising edge. In these notes, "bit period k" of a segment is the k-th falling edge counted from 0. Edge 0 is the falling edge at which the frame-sync change that opens the segment is first seen.

Top module: `audio_serial_port`

## Requirements
- R1: The format select encodes 00 left-justified, 01 I²S, 10 TDM and 11 reserved. Channel n (1 to 4) of `smp_data` occupies bits [24n-1 : 24(n-1)].
- R2: In TDM, a frame opens at a rising frame-sync edge. `sdout[0]` carries channels 1, 2, 3 and 4 in that order, in slots of 32 bit periods. Each slot sends its sample MSB first in bit periods 0 to 23 of the slot and zeros in periods 24 to 31. The channel 1 MSB is in bit period 0.
- R3: In TDM, `sdout[1]` is driven low for the whole frame.
- R4: Outputs change only on falling `bclk` edges, and frame sync is sampled on falling edges.
- R5: In left-justified mode, the frame-sync high half carries channel 1 on `sdout[0]` and channel 3 on `sdout[1]`. The low half carries channels 2 and 4 on the same pins. Each half puts the MSB in bit period 0 and zeros after the 24th bit.
- R6: In I²S, a frame opens at a falling frame-sync edge. The low half carries channels 1 and 3 and the high half carries channels 2 and 4. Bit period 0 of each half is zero, the MSB is in bit period 1, and bits after the LSB are zero.
- R7: Samples are taken from the latest staging contents at frame start. A load during a frame does not change the frame being sent.
- R8: A new format select value takes effect only at the frame-opening edge of the format in use: a falling edge while in I²S, a rising edge otherwise.
- R9: In the reserved format, both data pins are held low.
- R10: Synchronous reset clears both pins. They stay low until the first frame start after reset, and a frame-sync level held through reset is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state moves on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| fs | input | 1 | Frame sync level |
| fmt_sel | input | 2 | Framing select (R1 encoding) |
| smp_load | input | 1 | Write strobe for the staging register |
| smp_data | input | 96 | Four packed samples, channel 1 in the low bits |
| sdout | output | 2 | Serial data pins |

## Verification
The hardest situations to reach are the boundary cases where the framing switches. The format select changes mid-frame, and the new framing opens on the opposite frame-sync edge from the old one. The stimulus therefore runs an unbroken frame-sync stream through TDM, left-justified, I²S, reserved and back. Each switch is placed mid-frame, so the bench can confirm that the old framing finishes untouched and the new one starts on the correct edge. A sample load inside a frame, and a reset applied while frame sync is high, are placed in the same stream. These cover the holding-register and false-edge cases.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_TDM = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

endpackage

// File: rtl/fs_frame_ctl.sv
module fs_frame_ctl
  import audio_ser_pkg::*;
(
  input  logic       bclk,
  input  logic       rst,
  input  logic       fs,
  input  logic [1:0] fmt_sel,
  output fmt_e       fmt_eff,
  output logic       frame_start,
  output logic       half_start,
  output logic       running
);

  logic fs_q;
  fmt_e fmt_act;
  logic run_q;
  logic fs_rise, fs_fall, fmt_bound;

  always_comb begin
    fs_rise   = fs & ~fs_q;
    fs_fall   = ~fs & fs_q;
    // the framing in force decides which edge is its frame boundary
    fmt_bound = (fmt_act == FMT_I2S) ? fs_fall : fs_rise;
    fmt_eff   = fmt_bound ? fmt_e'(fmt_sel) : fmt_act;
    frame_start = ((fmt_eff == FMT_TDM || fmt_eff == FMT_LJ) && fs_rise) ||
                  ((fmt_eff == FMT_I2S) && fs_fall);
    half_start  = ((fmt_eff == FMT_LJ) && fs_fall) ||
                  ((fmt_eff == FMT_I2S) && fs_rise);
    running     = run_q | frame_start;
  end

  always_ff @(negedge bclk) begin
    fs_q <= fs;  // tracked through reset: no false edge afterwards (R10)
    if (rst) begin
      fmt_act <= FMT_RSV;
      run_q   <= 1'b0;
    end else begin
      if (fmt_bound)   fmt_act <= fmt_e'(fmt_sel);
      if (frame_start) run_q   <= 1'b1;
    end
  end

  // R8: the latched format only moves on a frame boundary
  p_fmt_hold_r8: assert property (@(negedge bclk) disable iff (rst)
    !fmt_bound |=> (fmt_act == $past(fmt_act)));

  // R4: a frame and a half cannot open on the same edge
  p_seg_excl_r4: assert property (@(negedge bclk) disable iff (rst)
    $onehot0({frame_start, half_start}));

endmodule

// File: rtl/smp_hold.sv
module smp_hold #(
  parameter int N_CH     = 4,
  parameter int SAMPLE_W = 24
) (
  input  logic                     bclk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [N_CH*SAMPLE_W-1:0] din,
  input  logic                     capture,
  output logic [N_CH*SAMPLE_W-1:0] words
);

  localparam int BUS_W = N_CH * SAMPLE_W;

  logic [BUS_W-1:0] stage_q;
  logic [BUS_W-1:0] hold_q;

  // at the opening edge the fresh staging contents are used directly
  assign words = capture ? stage_q : hold_q;

  always_ff @(negedge bclk) begin
    if (rst) begin
      stage_q <= '0;
      hold_q  <= '0;
    end else begin
      if (load)    stage_q <= din;
      if (capture) hold_q  <= stage_q;
    end
  end

  // R7: frame data frozen between frame starts
  p_hold_steady_r7: assert property (@(negedge bclk) disable iff (rst)
    !capture |=> $stable(hold_q));

endmodule

// File: rtl/bit_shifter.sv
module bit_shifter
  import audio_ser_pkg::*;
#(
  parameter int N_CH     = 4,
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic                     bclk,
  input  logic                     rst,
  input  fmt_e                     fmt_eff,
  input  logic                     frame_start,
  input  logic                     half_start,
  input  logic                     running,
  input  logic [N_CH*SAMPLE_W-1:0] words,
  output logic [N_CH/2-1:0]        sdout
);

  localparam int PINS       = N_CH / 2;
  localparam int FRAME_BITS = N_CH * SLOT_W;
  localparam int POS_W      = $clog2(FRAME_BITS + 1);
  localparam int IDX_W      = $clog2(N_CH * SAMPLE_W);

  logic [POS_W-1:0] pos_q, pos_use;
  logic             half_q, half_use;
  logic [PINS-1:0]  nxt;
  int               pu;

  // bit d (0 = MSB) of channel ch; out-of-range positions are padding
  function automatic logic pick(input logic [N_CH*SAMPLE_W-1:0] w,
                                input int ch, input int d);
    int idx;
    if (d < 0 || d >= SAMPLE_W || ch >= N_CH) return 1'b0;
    idx = ch * SAMPLE_W + SAMPLE_W - 1 - d;
    return w[IDX_W'(idx)];
  endfunction

  always_comb begin
    pos_use  = (frame_start || half_start) ? '0 : pos_q;
    half_use = half_start ? 1'b1 : (frame_start ? 1'b0 : half_q);
    pu       = int'(pos_use);
    nxt      = '0;
    if (running) begin
      for (int p = 0; p < PINS; p++) begin
        case (fmt_eff)
          FMT_TDM: nxt[p] = (p == 0) ? pick(words, pu / SLOT_W, pu % SLOT_W) : 1'b0;
          FMT_LJ:  nxt[p] = pick(words, 2 * p + int'(half_use), pu);
          FMT_I2S: nxt[p] = pick(words, 2 * p + int'(half_use), pu - 1);
          default: nxt[p] = 1'b0;
        endcase
      end
    end
  end

  always_ff @(negedge bclk) begin
    if (rst) begin
      pos_q  <= '0;
      half_q <= 1'b0;
      sdout  <= '0;
    end else begin
      pos_q  <= (pos_use == POS_W'(FRAME_BITS)) ? pos_use : pos_use + 1'b1;
      half_q <= half_use;
      sdout  <= nxt;
    end
  end

  // R3: only the first pin carries data in TDM
  p_tdm_side_low_r3: assert property (@(negedge bclk) disable iff (rst)
    (fmt_eff == FMT_TDM) |=> (sdout[PINS-1:1] == '0));

  // R2: slot padding after the sample bits
  p_tdm_pad_r2: assert property (@(negedge bclk) disable iff (rst)
    (fmt_eff == FMT_TDM && (pu % SLOT_W) >= SAMPLE_W) |=> (sdout[0] == 1'b0));

  // R9: reserved framing keeps the pins quiet
  p_rsv_quiet_r9: assert property (@(negedge bclk) disable iff (rst)
    (fmt_eff == FMT_RSV) |=> (sdout == '0));

  // R10: pins are clear when reset is released
  p_rst_clear_r10: assert property (@(negedge bclk) disable iff (rst)
    $fell(rst) |-> (sdout == '0));

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import audio_ser_pkg::*;
#(
  parameter int N_CH     = 4,
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic                     bclk,
  input  logic                     rst,
  input  logic                     fs,
  input  logic [1:0]               fmt_sel,
  input  logic                     smp_load,
  input  logic [N_CH*SAMPLE_W-1:0] smp_data,
  output logic [N_CH/2-1:0]        sdout
);

  localparam int BUS_W = N_CH * SAMPLE_W;

  fmt_e             fmt_eff;
  logic             frame_start;
  logic             half_start;
  logic             running;
  logic [BUS_W-1:0] words;

  fs_frame_ctl u_ctl (
    .bclk        (bclk),
    .rst         (rst),
    .fs          (fs),
    .fmt_sel     (fmt_sel),
    .fmt_eff     (fmt_eff),
    .frame_start (frame_start),
    .half_start  (half_start),
    .running     (running)
  );

  smp_hold #(.N_CH(N_CH), .SAMPLE_W(SAMPLE_W)) u_hold (
    .bclk    (bclk),
    .rst     (rst),
    .load    (smp_load),
    .din     (smp_data),
    .capture (frame_start),
    .words   (words)
  );

  bit_shifter #(.N_CH(N_CH), .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shift (
    .bclk        (bclk),
    .rst         (rst),
    .fmt_eff     (fmt_eff),
    .frame_start (frame_start),
    .half_start  (half_start),
    .running     (running),
    .words       (words),
    .sdout       (sdout)
  );

endmodule

// File: tb/sim_audio_serial_port.sv
`timescale 1ns/1ps
module sim_audio_serial_port;

  logic        bclk = 1'b0;
  logic        rst = 1'b1;
  logic        fs = 1'b0;
  logic [1:0]  fmt_sel = 2'b10;
  logic        smp_load = 1'b0;
  logic [95:0] smp_data = '0;
  logic [1:0]  sdout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    bit    chk;
    bit    e0;
    bit    e1;
    string tag;
  } item_t;
  item_t q[$];

  always #2.5 bclk = ~bclk;

  audio_serial_port u0 (
    .bclk(bclk), .rst(rst), .fs(fs), .fmt_sel(fmt_sel),
    .smp_load(smp_load), .smp_data(smp_data), .sdout(sdout)
  );

  // channel ch (0-based), bit d counted from the MSB; anything else is zero
  function automatic bit eb(input logic [95:0] v, input int ch, input int d);
    if (d < 0 || d > 23) return 1'b0;
    return v[24 * ch + 23 - d];
  endfunction

  task automatic drive(input logic fsv, input logic ld, input logic [95:0] ldv,
                       input logic rs, input bit e0, input bit e1,
                       input bit chk, input string tag);
    item_t it;
    @(posedge bclk);
    fs = fsv; smp_load = ld; rst = rs;
    if (ld) smp_data = ldv;
    it.chk = chk; it.e0 = e0; it.e1 = e1; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic quiet(input int n, input logic fsv, input logic rs, input int ld_at,
                       input logic [95:0] ldv, input bit chk, input string tag);
    for (int k = 0; k < n; k++)
      drive(fsv, k == ld_at, ldv, rs, 1'b0, 1'b0, chk, tag);
  endtask

  task automatic tdm_frame(input logic [95:0] v, input int ld_at, input logic [95:0] ldv,
                           input int fmt_at, input logic [1:0] fv, input string tag);
    for (int k = 0; k < 128; k++) begin
      if (k == fmt_at) fmt_sel = fv;
      drive(k < 64, k == ld_at, ldv, 1'b0, eb(v, k / 32, k % 32), 1'b0, 1'b1, tag);
    end
  endtask

  task automatic lj_frame(input logic [95:0] v, input int ld_at, input logic [95:0] ldv,
                          input int fmt_at, input logic [1:0] fv, input string tag);
    for (int k = 0; k < 64; k++) begin
      if (k == fmt_at) fmt_sel = fv;
      drive(k < 32, k == ld_at, ldv, 1'b0, eb(v, k / 32, k % 32),
            eb(v, 2 + k / 32, k % 32), 1'b1, tag);
    end
  endtask

  task automatic i2s_frame(input logic [95:0] v, input int ld_at, input logic [95:0] ldv,
                           input int fmt_at, input logic [1:0] fv, input string tag);
    for (int k = 0; k < 64; k++) begin
      if (k == fmt_at) fmt_sel = fv;
      drive(k >= 32, k == ld_at, ldv, 1'b0, eb(v, k / 32, k % 32 - 1),
            eb(v, 2 + k / 32, k % 32 - 1), 1'b1, tag);
    end
  endtask

  // monitor: compares one queued expectation per falling edge
  initial begin
    item_t it;
    forever begin
      @(negedge bclk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.chk) begin
          n_chk++;
          if (sdout !== {it.e1, it.e0}) begin
            n_fail++;
            $display("FAIL %s: sdout=%b expected %b at %0t", it.tag, sdout,
                     {it.e1, it.e0}, $time);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [95:0] A = {24'h5A5A5A, 24'h00FF01, 24'hC3A501, 24'h800001};
    logic [95:0] B = {24'h13579B, 24'hFFFFFF, 24'h000001, 24'hA00005};
    logic [95:0] C = {24'h2468AC, 24'h700F0E, 24'h9ABCDE, 24'h0C0C0C};
    logic [95:0] D = {24'hFEDCBA, 24'h012345, 24'h800000, 24'h55AA55};
    logic [95:0] E = {24'h111111, 24'h222222, 24'h333333, 24'h444444};
    logic [95:0] F = {24'hDEAD01, 24'hBEEF02, 24'hCAFE03, 24'hF00D04};
    logic [95:0] G = {24'h0F1E2D, 24'h3C4B5A, 24'h697887, 24'h96A5B4};
    logic [95:0] H = {24'hE1D2C3, 24'hB4A596, 24'h877869, 24'h5A4B3C};

    // R10: reset state, and quiet until the first frame opens
    quiet(4, 1'b0, 1'b1, -1, '0, 1'b1, "R10 reset");
    quiet(3, 1'b0, 1'b0, 1, A, 1'b1, "R10 idle");
    // R1 R2 R3 R4: TDM frame of A; R7: B loaded mid-frame
    tdm_frame(A, 40, B, -1, 2'b10, "R2 R3 R7 tdm A");
    // R8: switch to left-justified mid-frame, TDM completes unchanged
    tdm_frame(B, -1, '0, 70, 2'b00, "R2 R8 tdm B");
    // R5: left-justified frames
    lj_frame(B, 10, C, -1, 2'b00, "R5 lj B");
    lj_frame(C, -1, '0, 40, 2'b01, "R5 R8 lj C");
    // switch-over half, not checked
    quiet(32, 1'b1, 1'b0, 5, D, 1'b0, "xfer");
    // R6: I2S frames; R9 selected mid-frame and effective at the falling edge
    i2s_frame(D, -1, '0, -1, 2'b01, "R6 i2s D");
    i2s_frame(D, 20, E, 50, 2'b11, "R6 R7 R8 i2s D");
    // R9: reserved framing stays low while samples are loaded
    quiet(32, 1'b0, 1'b0, 4, F, 1'b1, "R9 rsv");
    quiet(32, 1'b1, 1'b0, -1, '0, 1'b1, "R9 rsv");
    quiet(32, 1'b0, 1'b0, -1, '0, 1'b1, "R9 rsv");
    quiet(32, 1'b1, 1'b0, -1, '0, 1'b1, "R9 rsv");
    fmt_sel = 2'b00;
    quiet(32, 1'b0, 1'b0, 13, G, 1'b1, "R8 R9 rsv");
    lj_frame(G, -1, '0, -1, 2'b00, "R5 R7 lj G");
    // R10: reset while frame sync is high; no frame until the next rising edge
    quiet(4, 1'b1, 1'b1, -1, '0, 1'b1, "R10 reset");
    quiet(28, 1'b1, 1'b0, -1, '0, 1'b1, "R10 no false edge");
    quiet(32, 1'b0, 1'b0, 3, H, 1'b1, "R10 idle");
    lj_frame(H, -1, '0, -1, 2'b00, "R5 R10 lj H");

    @(posedge bclk);
    @(posedge bclk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule